// File: doc/BRIEF.md
# Strided Gather-Scatter Address Generator

This unit moves one vector between memory and a vector register file. A single command selects one of four access modes: strided load, strided store, indexed load (gather) and indexed store (scatter). It also supplies a base address, a stride, a vector length and a per-element enable mask. The unit then issues one memory request per cycle for every enabled element below the length. Each request carries the element number as a tag. Returned load data are written back to the register element that the returned tag names.

For the indexed modes, the unit reads the per-element offset through a register read port. For the store modes, it reads the element's data through the same port; the register file answers in the same cycle. Disabled elements are skipped without spending a cycle, so the enabled elements form one back-to-back burst whenever memory is ready. The unit raises a one-cycle completion pulse when the vector has finished.

Top module: `vec_stream_agu`

## Requirements
- R1: Mode 2'b00 (strided load) issues element i with address base + i*stride (modulo 2^AW), tag i and write flag low.
- R2: Mode 2'b10 (strided store) issues element i at the address of R1 with the write flag high and write data equal to the data-register value read for element i.
- R3: Mode 2'b01 (gather) issues element i at base + offset[i], where offset[i] is the index-register value read for element i, with the write flag low.
- R4: Mode 2'b11 (scatter) issues element i at base + offset[i] with the write flag high and write data equal to data element i.
- R5: Only elements with i < length and mask bit i set are requested, in ascending element order; while ready stays high they go out one per cycle with no idle cycle between them.
- R6: While a request is pending and ready is low, the request's tag, address, write flag and write data stay unchanged.
- R7: Each load return drives a write-back of the returned data to the element given by the returned tag, in the same cycle.
- R8: Done is a one-cycle pulse. It comes in the cycle after the last request is accepted for stores, and in the cycle after the last return for loads. Busy falls after the done pulse, and after reset the unit is idle with no request.
- R9: A length of 0, or a mask with no enabled element, issues no request and gives done in the cycle after the command is taken.
- R10: A command presented while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a command (taken when idle) |
| cmd_mode | input | 2 | {store, indexed}: 00 strided load, 01 gather, 10 strided store, 11 scatter |
| cmd_base | input | AW | Base address |
| cmd_stride | input | AW | Element stride for strided modes |
| cmd_len | input | LW | Vector length, 0..VLEN |
| cmd_mask | input | VLEN | Per-element enable mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | output | EW | Element number read from the register file |
| rd_offset | input | AW | Index-register value for rd_idx |
| rd_data | input | DW | Data-register value for rd_idx |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_tag | output | EW | Element number of the request |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Load data returned |
| mem_rtag | input | EW | Element number of the returned data |
| mem_rdata | input | DW | Returned load data |
| wb_en | output | 1 | Write-back strobe to the register file |
| wb_idx | output | EW | Write-back element number |
| wb_data | output | DW | Write-back data |

## Verification
The assertions check four things on every cycle. A stalled request must hold still. Requested tags must rise strictly and stay below the length. Done must never last two cycles, and no request may appear while idle. The bench's scenarios are needed to show that addresses and write data match each mode's formula. Only those scenarios can also show that masked elements are missing from the stream, that bursts have no gap cycles, that write-back lands on the returned tag, that done arrives at the right cycle for zero-length vectors, and that a command given while busy leaves the stream untouched.

// File: rtl/vec_stream_agu.sv
module vec_stream_agu #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int VLEN = 8,
  localparam int EW = (VLEN > 1) ? $clog2(VLEN) : 1,
  localparam int LW = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_mode,
  input  logic [AW-1:0]   cmd_base,
  input  logic [AW-1:0]   cmd_stride,
  input  logic [LW-1:0]   cmd_len,
  input  logic [VLEN-1:0] cmd_mask,
  output logic            busy,
  output logic            done,
  output logic [EW-1:0]   rd_idx,
  input  logic [AW-1:0]   rd_offset,
  input  logic [DW-1:0]   rd_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [EW-1:0]   mem_tag,
  input  logic            mem_rdy,
  input  logic            mem_rvalid,
  input  logic [EW-1:0]   mem_rtag,
  input  logic [DW-1:0]   mem_rdata,
  output logic            wb_en,
  output logic [EW-1:0]   wb_idx,
  output logic [DW-1:0]   wb_data
);

  logic [1:0]      mode_q;
  logic [AW-1:0]   base_q, stride_q;
  logic [LW-1:0]   len_q;
  logic [VLEN-1:0] pend_q, len_mask, cur_onehot;
  logic [LW-1:0]   outst_q;
  logic [EW-1:0]   cur;
  logic            accept, fire, load_fire;

  always_comb begin
    cur = '0;
    for (int i = VLEN - 1; i >= 0; i--)
      if (pend_q[i]) cur = EW'(i);
  end

  always_comb
    for (int i = 0; i < VLEN; i++)
      len_mask[i] = (LW'(i) < cmd_len);

  assign cur_onehot = VLEN'(1) << cur;
  assign accept     = cmd_valid && !busy;
  assign mem_req    = busy && (pend_q != '0);
  assign fire       = mem_req && mem_rdy;
  assign load_fire  = fire && !mode_q[1];
  assign done       = busy && (pend_q == '0) && (outst_q == '0);

  assign rd_idx    = cur;
  assign mem_tag   = cur;
  assign mem_we    = mode_q[1];
  assign mem_wdata = rd_data;
  assign mem_addr  = mode_q[0] ? base_q + rd_offset
                               : base_q + AW'(AW'(cur) * stride_q);

  assign wb_en   = mem_rvalid && busy;
  assign wb_idx  = mem_rtag;
  assign wb_data = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_q   <= '0;
      base_q   <= '0;
      stride_q <= '0;
      len_q    <= '0;
      pend_q   <= '0;
      outst_q  <= '0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        mode_q   <= cmd_mode;
        base_q   <= cmd_base;
        stride_q <= cmd_stride;
        len_q    <= cmd_len;
        pend_q   <= cmd_mask & len_mask;
        outst_q  <= '0;
      end else begin
        if (done) busy <= 1'b0;
        if (fire) pend_q <= pend_q & ~cur_onehot;
        outst_q <= outst_q + LW'(load_fire) - LW'(wb_en);
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_tag) && $stable(mem_we)
                               && $stable(mem_addr) && $stable(mem_wdata)));

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!mem_req || (mem_tag > $past(mem_tag))));

  assert_in_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (LW'(mem_tag) < len_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !wb_en);

  assert_return_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (outst_q != '0));

endmodule

// File: tb/tb_vec_stream_agu.sv
module tb_vec_stream_agu;
  localparam int AW = 16, DW = 16, VLEN = 8, EW = 3, LW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_mode = 0;
  logic [AW-1:0] cmd_base = 0, cmd_stride = 0;
  logic [LW-1:0] cmd_len = 0;
  logic [VLEN-1:0] cmd_mask = 0;
  logic busy, done, mem_req, mem_we, wb_en;
  logic [EW-1:0] rd_idx, mem_tag, wb_idx;
  logic [AW-1:0] rd_offset, mem_addr;
  logic [DW-1:0] rd_data, mem_wdata, wb_data;
  logic mem_rdy = 1, mem_rvalid = 0;
  logic [EW-1:0] mem_rtag = 0;
  logic [DW-1:0] mem_rdata = 0;

  logic [AW-1:0] idx_rf [VLEN];
  logic [DW-1:0] dat_rf [VLEN];
  assign rd_offset = idx_rf[rd_idx];
  assign rd_data   = dat_rf[rd_idx];

  vec_stream_agu #(.AW(AW), .DW(DW), .VLEN(VLEN)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5b;

  logic [AW-1:0] q_addr[$];
  logic          q_we[$];
  logic [DW-1:0] q_wd[$];
  logic [EW-1:0] q_tag[$];
  logic [EW-1:0] q_wbi[$];
  logic [DW-1:0] q_wbd[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy <= stall_en ? lfsr[0] : 1'b1;
    mem_rvalid <= mem_req && mem_rdy && !mem_we;
    mem_rtag <= mem_tag;
    mem_rdata <= mem_addr ^ 16'hA5A5;
  end

  bit held = 0;
  logic [AW-1:0] h_addr; logic h_we; logic [DW-1:0] h_wd; logic [EW-1:0] h_tag;
  always @(negedge clk) if (rst_n) begin
    if (held) begin
      chk("R6 hold tag", mem_tag, h_tag);
      chk("R6 hold addr", mem_addr, h_addr);
      chk("R6 hold we/wdata", {mem_we, mem_wdata}, {h_we, h_wd});
    end
    held = mem_req && !mem_rdy;
    h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata; h_tag = mem_tag;
    if (mem_req && mem_rdy) begin
      if (q_tag.size() == 0) chk("R5 unexpected request tag", mem_tag, 'hx);
      else begin
        chk("R5 request order tag", mem_tag, q_tag.pop_front());
        chk("R1/R3 request addr", mem_addr, q_addr.pop_front());
        chk("R2/R4 request we", mem_we, q_we.pop_front());
        if (mem_we) chk("R2/R4 write data", mem_wdata, q_wd.pop_front());
        else void'(q_wd.pop_front());
      end
    end
    if (wb_en) begin
      if (q_wbi.size() == 0) chk("R7 unexpected writeback", wb_idx, 'hx);
      else begin
        chk("R7 writeback index", wb_idx, q_wbi.pop_front());
        chk("R7 writeback data", wb_data, q_wbd.pop_front());
      end
    end
  end

  task automatic run(string nm, logic [1:0] m, logic [AW-1:0] b, logic [AW-1:0] s,
                     logic [LW-1:0] l, logic [VLEN-1:0] mk, bit stall, bit interfere);
    int n = 0, cyc = 0;
    for (int i = 0; i < VLEN; i++) if (i < l && mk[i]) begin
      logic [AW-1:0] a;
      a = m[0] ? AW'(b + idx_rf[i]) : AW'(b + AW'(i) * s);
      q_addr.push_back(a); q_we.push_back(m[1]); q_wd.push_back(dat_rf[i]);
      q_tag.push_back(EW'(i));
      if (!m[1]) begin q_wbi.push_back(EW'(i)); q_wbd.push_back(a ^ 16'hA5A5); end
      n++;
    end
    stall_en = stall;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_mode = m; cmd_base = b; cmd_stride = s; cmd_len = l; cmd_mask = mk;
    @(posedge clk); #1;
    if (interfere) begin
      cmd_mode = ~m; cmd_base = b ^ 16'h0F0F; cmd_stride = s + 7; cmd_len = 4'd8; cmd_mask = 8'hFF;
    end else cmd_valid = 0;
    do begin
      @(negedge clk); cyc++;
      if (cyc == 2) cmd_valid = 0;
    end while (!done && cyc < 500);
    chk({nm, " R8 done seen"}, done, 1);
    if (l == 0 || n == 0) chk({nm, " R9 immediate done cycle"}, cyc, 1);
    else if (!stall) chk({nm, " R5/R8 burst length to done"}, cyc, m[1] ? n + 1 : n + 2);
    chk({nm, " R5 all requests issued"}, q_tag.size(), 0);
    chk({nm, " R7 all writebacks seen"}, q_wbi.size(), 0);
    @(negedge clk);
    chk({nm, " R8 done is one pulse, busy low"}, {done, busy}, 0);
    q_addr.delete(); q_we.delete(); q_wd.delete(); q_tag.delete(); q_wbi.delete(); q_wbd.delete();
    stall_en = 0;
  endtask

  initial begin
    for (int i = 0; i < VLEN; i++) begin
      dat_rf[i] = DW'(16'h1000 + i * 17);
      idx_rf[i] = AW'(i * 37 + 3);
    end
    idx_rf[2] = 16'hFFF0; idx_rf[5] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset idle", {busy, done, mem_req}, 0);
    rst_n = 1;
    run("slod1", 2'b00, 16'h0100, 16'd1, 4'd8, 8'hFF, 0, 0);
    run("slod5", 2'b00, 16'hFFF8, 16'd5, 4'd5, 8'b1111_0110, 0, 0);
    run("sst3",  2'b10, 16'h2000, 16'd3, 4'd7, 8'hFF, 1, 0);
    run("sst_nostall", 2'b10, 16'h3000, 16'h0040, 4'd6, 8'b0010_1101, 0, 0);
    run("gath",  2'b01, 16'h4000, 16'd0, 4'd8, 8'b1011_0101, 1, 0);
    run("gath2", 2'b01, 16'h0020, 16'd0, 4'd8, 8'hFF, 0, 0);
    run("scat",  2'b11, 16'h8000, 16'd0, 4'd6, 8'hFF, 0, 0);
    run("scat_st", 2'b11, 16'h0010, 16'd0, 4'd8, 8'b1100_0011, 1, 0);
    run("len0",  2'b00, 16'h1234, 16'd1, 4'd0, 8'hFF, 0, 0);
    run("allmask", 2'b11, 16'h1234, 16'd1, 4'd4, 8'b1111_0000, 0, 0);
    run("R10 busy cmd", 2'b00, 16'h0500, 16'd2, 4'd6, 8'hFF, 0, 1);
    run("R10 busy cmd stall", 2'b01, 16'h0600, 16'd0, 4'd8, 8'b0111_1110, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule